// File: doc/BRIEF.md
# Reconfigurable Block Transpose FIR Filter

This block is a block-processing FIR filter in transposed structure. Every valid cycle it takes a block of L signed samples and, a fixed number of cycles later, returns L filtered samples. The N taps are split into M = N/L short weight vectors. A row stage builds L overlapping sample rows from the current and previous block and sends the same rows to all M inner-product units. Each unit applies its own weight vector, and a registered adder chain sums the partial results across blocks in transposed order.

The coefficients are reconfigurable. A store holds NSETS complete tap sets, and software-style writes load them one tap at a time. A set selector travels with each input block, so a new set applies from a block boundary onward. Arithmetic is signed two's complement and full precision. Outputs are sized so that no sum can overflow.

Top module: `fir_tf_block`

## Requirements
- R1: `out_valid_o` rises exactly 3 rising clock edges after the edge that samples `in_valid_i` high, and there is one output block for each accepted input block.
- R2: Input lane i (bits i*DW upward) holds sample x[kL+i] of block k. Output lane j (bits j*AW upward, AW = DW+CW+ceil(log2 N)) holds y[kL+j] = sum over t of h[t]*x[kL+j-t]. Samples before the first accepted block count as zero.
- R3: `coef_sel_i` is sampled with each valid block. The taps t from m*L to m*L+L-1 of output block k use the set that was sampled with input block k-m. A switch therefore shows in full after M blocks.
- R4: A write with `coef_we_i` high stores `coef_data_i` into tap `coef_tap_i` of set `coef_set_i` at that edge. Writes to a set that is not selected do not disturb the outputs.
- R5: When `in_valid_i` is low, the block ignores `in_data_i` and `coef_sel_i`, and the filter history does not advance. A stream with idle gaps gives the same outputs as the same stream without gaps.
- R6: Reset clears the outputs, `out_valid_o`, the sample history and all coefficients to zero. After a reset the next outputs depend only on blocks sent after it.
- R7: The extreme case, all samples and all taps at the most negative value, is computed exactly (N * 2^(DW+CW-2)) with no wrap.
- R8: `out_data_o` holds its value while `out_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input block qualifier |
| in_data_i | input | L*DW | L signed samples, oldest in lane 0 |
| coef_sel_i | input | SW | Coefficient set for this block |
| coef_we_i | input | 1 | Coefficient write strobe |
| coef_set_i | input | SW | Set addressed by the write |
| coef_tap_i | input | TW | Tap addressed by the write |
| coef_data_i | input | CW | Signed tap value |
| out_valid_o | output | 1 | Output block qualifier |
| out_data_o | output | L*AW | L signed results, oldest in lane 0 |

## Verification
An impulse against a ramp of taps shows the tap order and the lane order, and makes a swapped lane or a misplaced weight vector easy to find. Random back-to-back streams test the cross-block rows and the chain of registers. The same traffic with idle cycles and junk data between blocks tells a history that stalls correctly apart from one that keeps running. Switching sets every block separates a selector that travels with its block from one applied to the whole chain. All-negative extremes expose any loss of width in the sums.

// File: rtl/fir_tf_pkg.sv
package fir_tf_pkg;
  localparam int unsigned PIPE_LAT = 3;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/fir_tf_rows.sv
module fir_tf_rows #(
  parameter int L  = 4,
  parameter int DW = 16,
  parameter int SW = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          valid_i,
  input  logic [L-1:0][DW-1:0]          data_i,
  input  logic [SW-1:0]                 sel_i,
  output logic                          valid_o,
  output logic [SW-1:0]                 sel_o,
  output logic [L-1:0][L-1:0][DW-1:0]   rows_o
);
  logic [L-1:0][DW-1:0] cur_q, prev_q;
  logic [SW-1:0]        sel_q;
  logic                 valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q   <= '0;
      prev_q  <= '0;
      sel_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        cur_q  <= data_i;
        prev_q <= cur_q;
        sel_q  <= sel_i;
      end
    end
  end

  // rows_o[j][l] = x[kL + j - l]
  for (genvar j = 0; j < L; j++) begin : g_row
    for (genvar l = 0; l < L; l++) begin : g_col
      if (j >= l) begin : g_cur
        assign rows_o[j][l] = cur_q[j-l];
      end else begin : g_prev
        assign rows_o[j][l] = prev_q[L+j-l];
      end
    end
  end

  assign valid_o = valid_q;
  assign sel_o   = sel_q;

  p_idle_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(cur_q) && $stable(prev_q) && $stable(sel_q)));
endmodule

// File: rtl/fir_tf_coefs.sv
module fir_tf_coefs #(
  parameter int NSETS = 4,
  parameter int N     = 32,
  parameter int L     = 4,
  parameter int CW    = 16,
  parameter int SW    = 2,
  parameter int TW    = 5,
  localparam int M    = N / L
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [SW-1:0]                wset_i,
  input  logic [TW-1:0]                wtap_i,
  input  logic [CW-1:0]                wdata_i,
  input  logic [SW-1:0]                rd_set_i,
  output logic [M-1:0][L-1:0][CW-1:0]  weights_o
);
  logic [NSETS-1:0][N-1:0][CW-1:0] mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
    end else if (we_i) begin
      mem_q[wset_i][wtap_i] <= wdata_i;
    end
  end

  for (genvar m = 0; m < M; m++) begin : g_vec
    for (genvar l = 0; l < L; l++) begin : g_tap
      assign weights_o[m][l] = mem_q[rd_set_i][m*L+l];
    end
  end

  p_write_lands_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(wset_i)][$past(wtap_i)] == $past(wdata_i));
endmodule

// File: rtl/fir_tf_ipu.sv
module fir_tf_ipu #(
  parameter int L  = 4,
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int AW = 37,
  localparam int PW = DW + CW
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        valid_i,
  input  logic [L-1:0][L-1:0][DW-1:0] rows_i,
  input  logic [L-1:0][CW-1:0]        w_i,
  output logic [L-1:0][AW-1:0]        p_o
);
  logic [L-1:0][AW-1:0] sum_d, p_q;

  always_comb begin
    for (int j = 0; j < L; j++) begin
      logic [AW-1:0] acc;
      acc = '0;
      for (int l = 0; l < L; l++) begin
        logic signed [PW-1:0] prod;
        prod = $signed(rows_i[j][l]) * $signed(w_i[l]);
        acc  = acc + {{(AW-PW){prod[PW-1]}}, prod};
      end
      sum_d[j] = acc;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) p_q <= '0;
    else if (valid_i) p_q <= sum_d;
  end

  assign p_o = p_q;
endmodule

// File: rtl/fir_tf_chain.sv
module fir_tf_chain #(
  parameter int L  = 4,
  parameter int M  = 8,
  parameter int AW = 37
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        valid_i,
  input  logic [M-1:0][L-1:0][AW-1:0] p_i,
  output logic                        valid_o,
  output logic [L-1:0][AW-1:0]        y_o
);
  logic [L-1:0][AW-1:0] y_q;
  logic                 valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= valid_i;
  end

  if (M == 1) begin : g_single
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) y_q <= '0;
      else if (valid_i) y_q <= p_i[0];
    end
  end else begin : g_multi
    // d_q[m] carries the partial sum of units m..M-1, one block late per stage
    logic [M-1:1][L-1:0][AW-1:0] d_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        d_q <= '0;
        y_q <= '0;
      end else if (valid_i) begin
        d_q[M-1] <= p_i[M-1];
        for (int m = 1; m < M - 1; m++) begin
          for (int j = 0; j < L; j++) d_q[m][j] <= p_i[m][j] + d_q[m+1][j];
        end
        for (int j = 0; j < L; j++) y_q[j] <= p_i[0][j] + d_q[1][j];
      end
    end

    p_chain_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> $stable(d_q));
  end

  assign valid_o = valid_q;
  assign y_o     = y_q;

  p_out_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(y_o));
endmodule

// File: rtl/fir_tf_block.sv
module fir_tf_block
  import fir_tf_pkg::*;
#(
  parameter int L      = 4,
  parameter int N      = 32,
  parameter int DW     = 16,
  parameter int CW     = 16,
  parameter int NSETS  = 4,
  localparam int M     = N / L,
  localparam int SW    = idx_w(NSETS),
  localparam int TW    = idx_w(N),
  localparam int AW    = DW + CW + idx_w(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [L*DW-1:0]   in_data_i,
  input  logic [SW-1:0]     coef_sel_i,
  input  logic              coef_we_i,
  input  logic [SW-1:0]     coef_set_i,
  input  logic [TW-1:0]     coef_tap_i,
  input  logic [CW-1:0]     coef_data_i,
  output logic              out_valid_o,
  output logic [L*AW-1:0]   out_data_o
);
  logic [L-1:0][L-1:0][DW-1:0]  rows;
  logic [L-1:0][DW-1:0]         blk;
  logic [SW-1:0]                act_sel;
  logic                         rows_valid;
  logic                         prod_valid_q;
  logic [M-1:0][L-1:0][CW-1:0]  weights;
  logic [M-1:0][L-1:0][AW-1:0]  partial;
  logic [L-1:0][AW-1:0]         y;

  assign blk = in_data_i;

  fir_tf_rows #(.L(L), .DW(DW), .SW(SW)) u_rows (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (in_valid_i),
    .data_i  (blk),
    .sel_i   (coef_sel_i),
    .valid_o (rows_valid),
    .sel_o   (act_sel),
    .rows_o  (rows)
  );

  fir_tf_coefs #(.NSETS(NSETS), .N(N), .L(L), .CW(CW), .SW(SW), .TW(TW)) u_coefs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (coef_we_i),
    .wset_i    (coef_set_i),
    .wtap_i    (coef_tap_i),
    .wdata_i   (coef_data_i),
    .rd_set_i  (act_sel),
    .weights_o (weights)
  );

  for (genvar m = 0; m < M; m++) begin : g_ipu
    fir_tf_ipu #(.L(L), .DW(DW), .CW(CW), .AW(AW)) u_ipu (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (rows_valid),
      .rows_i  (rows),
      .w_i     (weights[m]),
      .p_o     (partial[m])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prod_valid_q <= 1'b0;
    else         prod_valid_q <= rows_valid;
  end

  fir_tf_chain #(.L(L), .M(M), .AW(AW)) u_chain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (prod_valid_q),
    .p_i     (partial),
    .valid_o (out_valid_o),
    .y_o     (y)
  );

  assign out_data_o = y;

  p_latency_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o == $past(in_valid_i, PIPE_LAT));
endmodule

// File: tb/tb_fir_tf_block.sv
`timescale 1ns/1ps
module tb_fir_tf_block;
  localparam int L = 4, N = 32, DW = 16, CW = 16, NSETS = 4;
  localparam int AW = DW + CW + 5;
  localparam int SW = 2, TW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [L*DW-1:0] in_data = '0;
  logic [SW-1:0] coef_sel = '0, coef_set = '0;
  logic coef_we = 1'b0;
  logic [TW-1:0] coef_tap = '0;
  logic [CW-1:0] coef_data = '0;
  logic out_valid;
  logic [L*AW-1:0] out_data;

  always #5 clk = ~clk;

  fir_tf_block #(.L(L), .N(N), .DW(DW), .CW(CW), .NSETS(NSETS)) dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_data_i(in_data),
    .coef_sel_i(coef_sel), .coef_we_i(coef_we), .coef_set_i(coef_set),
    .coef_tap_i(coef_tap), .coef_data_i(coef_data),
    .out_valid_o(out_valid), .out_data_o(out_data)
  );

  int checks = 0, errors = 0;
  longint xs[2048];
  int bs[512];
  longint href[NSETS][N];
  int nin = 0, nout = 0;
  string tag = "R2";

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint ref_y(input int n);
    longint s = 0;
    int k = n / L;
    for (int t = 0; t < N; t++) begin
      if (n - t >= 0) s += href[bs[k - t / L]][t] * xs[n - t];
    end
    return s;
  endfunction

  // output monitor: every lane compared with the direct-form reference
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      for (int j = 0; j < L; j++) begin
        longint act, exp;
        act = longint'($signed(out_data[j*AW +: AW]));
        exp = (nout < nin) ? ref_y(nout * L + j) : 64'sd0;
        chk(act == exp && nout < nin, tag, act, exp);
      end
      nout++;
    end
  end

  function automatic logic [L*DW-1:0] rnd_blk();
    logic [L*DW-1:0] r;
    for (int i = 0; i < L; i++) r[i*DW +: DW] = DW'($urandom);
    return r;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    nin = 0;
    nout = 0;
    for (int s = 0; s < NSETS; s++)
      for (int t = 0; t < N; t++) href[s][t] = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic write_coef(input int s, input int t, input longint v);
    coef_we = 1'b1;
    coef_set = SW'(s);
    coef_tap = TW'(t);
    coef_data = CW'(v);
    @(negedge clk);
    coef_we = 1'b0;
    href[s][t] = v;
  endtask

  task automatic load_set(input int s, input int mode);
    for (int t = 0; t < N; t++) begin
      longint v;
      case (mode)
        0: v = t + 1;
        1: v = longint'($signed(CW'($urandom)));
        2: v = -32768;
        default: v = (t % 3) - 1;
      endcase
      write_coef(s, t, v);
    end
  endtask

  task automatic send(input logic [L*DW-1:0] d, input int sel);
    in_valid = 1'b1;
    in_data = d;
    coef_sel = SW'(sel);
    for (int i = 0; i < L; i++) xs[nin*L + i] = longint'($signed(d[i*DW +: DW]));
    bs[nin] = sel;
    nin++;
    @(negedge clk);
    in_valid = 1'b0;
    in_data = rnd_blk();
    coef_sel = SW'($urandom);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      in_data = rnd_blk();
      coef_sel = SW'($urandom);
      @(negedge clk);
    end
  endtask

  task automatic drain(input string req);
    idle(6);
    chk(nout == nin, req, nout, nin); // R1: one output block per input block
  endtask

  task automatic t_reset_state();
    do_reset();
    chk(out_valid == 1'b0, "R6", out_valid, 0);
    chk(out_data == '0, "R6", longint'(out_data[63:0]), 0);
    tag = "R6";
    for (int b = 0; b < 3; b++) send(rnd_blk(), 0); // zero coefficients after reset
    drain("R6");
  endtask

  task automatic t_impulse();
    logic [L*DW-1:0] d;
    do_reset();
    load_set(0, 0);
    tag = "R2";
    d = '0;
    d[DW-1:0] = DW'(1);
    send(d, 0);
    for (int b = 0; b < N / L + 1; b++) send('0, 0);
    drain("R2");
  endtask

  task automatic t_random_stream();
    do_reset();
    load_set(0, 1);
    tag = "R2";
    for (int b = 0; b < 24; b++) send(rnd_blk(), 0);
    drain("R2");
  endtask

  task automatic t_gaps();
    do_reset();
    load_set(1, 1);
    tag = "R5";
    for (int b = 0; b < 20; b++) begin
      send(rnd_blk(), 1);
      idle($urandom_range(0, 3));
    end
    drain("R5");
  endtask

  task automatic t_switch();
    do_reset();
    load_set(0, 1);
    load_set(1, 3);
    tag = "R3";
    for (int b = 0; b < 30; b++) send(rnd_blk(), (b / 3) % 2);
    drain("R3");
  endtask

  task automatic t_write_isolation();
    do_reset();
    load_set(1, 1);
    tag = "R4";
    for (int b = 0; b < 12; b++) begin
      in_valid = 1'b1;
      in_data = rnd_blk();
      coef_sel = SW'(1);
      for (int i = 0; i < L; i++) xs[nin*L + i] = longint'($signed(in_data[i*DW +: DW]));
      bs[nin] = 1;
      nin++;
      write_coef(2, b, b * 7 - 40); // inactive set written during streaming
    end
    in_valid = 1'b0;
    for (int b = 0; b < 12; b++) send(rnd_blk(), 2);
    drain("R4");
  endtask

  task automatic t_extreme();
    logic [L*DW-1:0] d;
    longint last;
    do_reset();
    load_set(3, 2);
    tag = "R7";
    for (int i = 0; i < L; i++) d[i*DW +: DW] = {1'b1, {(DW-1){1'b0}}};
    for (int b = 0; b < N / L + 2; b++) send(d, 3);
    idle(3);
    last = longint'($signed(out_data[(L-1)*AW +: AW]));
    chk(last == 64'sd34359738368, "R7", last, 64'sd34359738368);
    drain("R7");
  endtask

  task automatic t_latency_hold();
    int cnt;
    logic [L*AW-1:0] snap;
    do_reset();
    load_set(0, 1);
    tag = "R1";
    in_valid = 1'b1;
    in_data = rnd_blk();
    coef_sel = '0;
    for (int i = 0; i < L; i++) xs[i] = longint'($signed(in_data[i*DW +: DW]));
    bs[0] = 0;
    nin = 1;
    cnt = 0;
    do begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
      if (cnt == 1) in_valid = 1'b0;
    end while (!out_valid && cnt < 10);
    chk(cnt == 3, "R1", cnt, 3);
    snap = out_data;
    idle(5);
    chk(out_valid == 1'b0, "R8", out_valid, 0);
    chk(out_data == snap, "R8", longint'(out_data[63:0]), longint'(snap[63:0]));
    drain("R1");
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset_state();
    t_impulse();
    t_random_stream();
    t_gaps();
    t_switch();
    t_write_isolation();
    t_extreme();
    t_latency_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule